// File: doc/BRIEF.md
# Segmented Ternary-Free CAM with Global Compare Mask

This block is a small content-addressable memory of 64-bit words. A 3-bit partition code splits every word the same way into a compared (key) part and an uncompared (associated data) part. The split always falls on a 16-bit segment boundary. An optional global bit mask can take further bit positions out of the compare. A search key is applied against all valid words at once. The block returns a hit flag, a multiple-hit flag, the lowest matching address and the full word stored at that address, so the uncompared segments serve as looked-up data.

Words and their valid bits are written by address and can be read back by address. The partition code, the mask enable and the mask value are loaded together through one configuration strobe. Typical uses are address filtering and dictionary lookup, where a key held in the compared segments retrieves the data kept beside it.

Top module: `cam_array`

## Requirements
- R1: While rst_ni is low, every valid bit is cleared, the partition code becomes 0, masking is disabled, and hit_o, multi_o, hit_addr_o, hit_data_o, rd_data_o and rd_valid_o are all 0.
- R2: When wr_en_i is high, the word wr_data_i and the valid bit wr_valid_i are stored at wr_addr_i. When rd_en_i is high, the word and valid bit at rd_addr_i appear on rd_data_o and rd_valid_o one cycle later and hold until the next read. A read of an address written in the same cycle returns the old contents.
- R3: When cmp_en_i is high, the search result appears on hit_o, multi_o, hit_addr_o and hit_data_o one cycle later. These outputs hold until the next search.
- R4: A word whose valid bit is 0 never matches.
- R5: Segment k is bits 16k+15 to 16k. Partition codes 0, 1, 2 and 3 compare segments 3..0, 3..1, 3..2 and 3 only. Codes 4, 5 and 6 compare segments 2..0, 1..0 and 0 only. Code 7 compares all four segments, like code 0.
- R6: Bits outside the compared segments never affect matching. hit_data_o carries the full 64-bit stored word of the reported address, including those bits.
- R7: When masking is enabled, each 1 bit in the mask excludes that bit position from the compare for all words. When masking is disabled, the mask value has no effect.
- R8: hit_addr_o is the lowest-numbered matching address. multi_o is 1 exactly when two or more words match.
- R9: When no word matches, hit_o, multi_o, hit_addr_o and hit_data_o are all 0.
- R10: A search sees the array and the configuration as they were before any write or configuration load in the same cycle. A configuration load takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load partition code, mask enable and mask |
| cfg_part_i | input | 3 | Partition code |
| cfg_mask_en_i | input | 1 | Enable the global mask for searches |
| cfg_mask_i | input | 64 | Global mask, 1 excludes the bit |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | 64 | Word to store |
| wr_valid_i | input | 1 | Valid bit to store |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | 64 | Word read |
| rd_valid_o | output | 1 | Valid bit read |
| cmp_en_i | input | 1 | Search strobe |
| cmp_key_i | input | 64 | Search key |
| hit_o | output | 1 | At least one word matched |
| multi_o | output | 1 | Two or more words matched |
| hit_addr_o | output | AW | Lowest matching address |
| hit_data_o | output | 64 | Stored word at hit_addr_o |

## Verification
Search results and read data are both due exactly one cycle after their strobe. Both are taken from the contents and configuration that were in place before that edge's writes and loads. The bench drives every stimulus at a falling edge. It then moves its behavioural model forward in the same order: it first forms the expected search and read results from the old contents, and only then applies the writes and the configuration load. It compares all six outputs at the next falling edge, one full cycle later. Outputs that are not refreshed are expected to hold, so a stray update is caught in whichever cycle it occurs.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned SEG_W  = 16;
  localparam int unsigned NSEG   = 4;
  localparam int unsigned WORD_W = SEG_W * NSEG;
  localparam int unsigned PART_W = 3;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NSEG-1:0]   seg_vec_t;

  // bit k set: segment k takes part in the compare
  function automatic seg_vec_t part_segs(logic [PART_W-1:0] code);
    unique case (code)
      3'd1:    return 4'b1110;
      3'd2:    return 4'b1100;
      3'd3:    return 4'b1000;
      3'd4:    return 4'b0111;
      3'd5:    return 4'b0011;
      3'd6:    return 4'b0001;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/cam_cfg.sv
module cam_cfg
  import cam_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [PART_W-1:0] cfg_part_i,
  input  logic              cfg_mask_en_i,
  input  word_t             cfg_mask_i,
  output word_t             care_o
);
  logic [PART_W-1:0] part_q;
  logic              men_q;
  word_t             mask_q;
  seg_vec_t          segs;
  word_t             seg_care;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q <= '0;
      men_q  <= 1'b0;
      mask_q <= '0;
    end else if (cfg_we_i) begin
      part_q <= cfg_part_i;
      men_q  <= cfg_mask_en_i;
      mask_q <= cfg_mask_i;
    end
  end

  assign segs = part_segs(part_q);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_care[s*SEG_W +: SEG_W] = {SEG_W{segs[s]}};
  end

  assign care_o = men_q ? (seg_care & ~mask_q) : seg_care;
endmodule

// File: rtl/cam_store.sv
module cam_store
  import cam_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  word_t            wr_data_i,
  input  logic             wr_valid_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output word_t            rd_data_o,
  output logic             rd_valid_o,
  input  word_t            key_i,
  input  word_t            care_i,
  output logic [DEPTH-1:0] match_o,
  input  logic [AW-1:0]    sel_addr_i,
  output word_t            sel_data_o,
  output logic [DEPTH-1:0] valid_o
);
  word_t            mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q      <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      if (wr_en_i) vld_q[wr_addr_i] <= wr_valid_i;
      if (rd_en_i) begin
        rd_data_o  <= mem_q[rd_addr_i];
        rd_valid_o <= vld_q[rd_addr_i];
      end
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_line
    assign match_o[e] = vld_q[e] && (((mem_q[e] ^ key_i) & care_i) == '0);
  end

  assign sel_data_o = mem_q[sel_addr_i];
  assign valid_o    = vld_q;
endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req_i,
  output logic             any_o,
  output logic             multi_o,
  output logic [AW-1:0]    addr_o
);
  always_comb begin
    addr_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req_i[i]) addr_o = AW'(i);
    end
  end

  assign any_o   = |req_i;
  // clearing the lowest set bit leaves something only if two or more were set
  assign multi_o = |(req_i & (req_i - DEPTH'(1)));
endmodule

// File: rtl/cam_array.sv
module cam_array
  import cam_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [PART_W-1:0] cfg_part_i,
  input  logic              cfg_mask_en_i,
  input  logic [63:0]       cfg_mask_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [63:0]       wr_data_i,
  input  logic              wr_valid_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [63:0]       rd_data_o,
  output logic              rd_valid_o,
  input  logic              cmp_en_i,
  input  logic [63:0]       cmp_key_i,
  output logic              hit_o,
  output logic              multi_o,
  output logic [AW-1:0]     hit_addr_o,
  output logic [63:0]       hit_data_o
);
  word_t            care_w;
  word_t            sel_data_w;
  logic [DEPTH-1:0] match_w;
  logic [DEPTH-1:0] valid_w;
  logic             any_w;
  logic             multi_w;
  logic [AW-1:0]    addr_w;

  cam_cfg u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_part_i    (cfg_part_i),
    .cfg_mask_en_i (cfg_mask_en_i),
    .cfg_mask_i    (cfg_mask_i),
    .care_o        (care_w)
  );

  cam_store #(.DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .wr_valid_i (wr_valid_i),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .key_i      (cmp_key_i),
    .care_i     (care_w),
    .match_o    (match_w),
    .sel_addr_i (addr_w),
    .sel_data_o (sel_data_w),
    .valid_o    (valid_w)
  );

  cam_prio #(.DEPTH(DEPTH)) u_prio (
    .req_i   (match_w),
    .any_o   (any_w),
    .multi_o (multi_w),
    .addr_o  (addr_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o      <= 1'b0;
      multi_o    <= 1'b0;
      hit_addr_o <= '0;
      hit_data_o <= '0;
    end else if (cmp_en_i) begin
      hit_o      <= any_w;
      multi_o    <= multi_w;
      hit_addr_o <= any_w ? addr_w : '0;
      hit_data_o <= any_w ? sel_data_w : '0;
    end
  end

  // checker state
  logic [DEPTH-1:0] vld_d1;
  logic             cmp_d1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_d1 <= '0;
      cmp_d1 <= 1'b0;
    end else begin
      vld_d1 <= valid_w;
      cmp_d1 <= cmp_en_i;
    end
  end

  a_r8_multi_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> hit_o);

  a_r9_miss_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (hit_addr_o == '0 && hit_data_o == '0 && !multi_o));

  a_r4_hit_is_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_d1 && hit_o) |-> vld_d1[hit_addr_o]);

  a_r7_full_mask_any_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && care_w == '0) |=> (hit_o == $past(|valid_w)));
endmodule

// File: tb/cam_array_tb_top.sv
module cam_array_tb_top;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 0, cfg_men = 0, wr_en = 0, wr_vld = 0, rd_en = 0, cmp_en = 0;
  logic [2:0]    cfg_part = 0;
  logic [63:0]   cfg_mask = 0, wr_data = 0, key = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [63:0]   rd_data, hit_data;
  logic          rd_vld, hit, multi;
  logic [AW-1:0] hit_addr;

  int checks = 0;
  int errors = 0;

  always #4ns clk = ~clk;

  cam_array #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_part_i(cfg_part), .cfg_mask_en_i(cfg_men), .cfg_mask_i(cfg_mask),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_valid_i(wr_vld),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_valid_o(rd_vld),
    .cmp_en_i(cmp_en), .cmp_key_i(key),
    .hit_o(hit), .multi_o(multi), .hit_addr_o(hit_addr), .hit_data_o(hit_data)
  );

  // reference model
  logic [63:0] m_data [DEPTH];
  bit          m_vld  [DEPTH];
  int          m_part = 0;
  bit          m_men = 0;
  logic [63:0] m_mask = 0;
  bit          e_hit = 0, e_multi = 0, e_rvld = 0;
  int          e_addr = 0;
  logic [63:0] e_hdata = 0, e_rdata = 0;

  function automatic logic [63:0] care_of(int code, bit men, logic [63:0] mk);
    logic [63:0] c = '0;
    for (int k = 0; k < 4; k++) begin
      bit on;
      if (code >= 7)     on = 1;
      else if (code < 4) on = (k >= code);
      else               on = (k <= 6 - code);
      if (on) c[16*k +: 16] = 16'hffff;
    end
    if (men) c = c & ~mk;
    return c;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %0h exp %0h", req, what, act, exp);
    end
  endtask

  // one clock: model results from old state, then model update, then compare
  task automatic tick(string req);
    if (cmp_en) begin
      logic [63:0] c = care_of(m_part, m_men, m_mask);
      int n = 0;
      e_addr = 0;
      for (int i = DEPTH - 1; i >= 0; i--)
        if (m_vld[i] && ((m_data[i] ^ key) & c) == 0) begin
          n++;
          e_addr = i;
        end
      e_hit   = (n > 0);
      e_multi = (n > 1);
      e_hdata = e_hit ? m_data[e_addr] : 64'h0;
    end
    if (rd_en) begin
      e_rdata = m_data[rd_addr];
      e_rvld  = m_vld[rd_addr];
    end
    if (wr_en) begin
      m_data[wr_addr] = wr_data;
      m_vld[wr_addr]  = wr_vld;
    end
    if (cfg_we) begin
      m_part = cfg_part;
      m_men  = cfg_men;
      m_mask = cfg_mask;
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, "hit_o",      64'(hit),      64'(e_hit));
    chk(req, "multi_o",    64'(multi),    64'(e_multi));
    chk(req, "hit_addr_o", 64'(hit_addr), 64'(e_addr));
    chk(req, "hit_data_o", hit_data,      e_hdata);
    chk(req, "rd_data_o",  rd_data,       e_rdata);
    chk(req, "rd_valid_o", 64'(rd_vld),   64'(e_rvld));
    cfg_we = 0; wr_en = 0; rd_en = 0; cmp_en = 0;
  endtask

  task automatic wr(int a, logic [63:0] d, bit v, string req);
    wr_en = 1; wr_addr = AW'(a); wr_data = d; wr_vld = v; tick(req);
  endtask
  task automatic cfg(int p, bit men, logic [63:0] mk, string req);
    cfg_we = 1; cfg_part = 3'(p); cfg_men = men; cfg_mask = mk; tick(req);
  endtask
  task automatic srch(logic [63:0] k, string req);
    cmp_en = 1; key = k; tick(req);
  endtask
  task automatic rd(int a, string req);
    rd_en = 1; rd_addr = AW'(a); tick(req);
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog expired act 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = 0; m_vld[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset values visible at ports
    chk("R1", "hit_o", 64'(hit), 0);
    chk("R1", "rd_valid_o", 64'(rd_vld), 0);
    chk("R1", "hit_data_o", hit_data, 0);
    rst_n = 1;
    // R1: all valid bits cleared: an all-care search misses
    srch(64'h0, "R1");
    // fill every word, all invalid
    for (int i = 0; i < DEPTH; i++) wr(i, {32'hdead0000 | 32'(i), 32'h0}, 0, "R2");
    rd(5, "R2");
    srch({32'hdead0005, 32'h0}, "R4");
    // valid words
    wr(10, 64'h1111_2222_3333_4444, 1, "R2");
    wr(20, 64'h1111_2222_3333_5555, 1, "R2");
    wr(30, 64'haaaa_2222_3333_4444, 1, "R2");
    rd(10, "R2");
    rd(11, "R2");
    srch(64'h1111_2222_3333_4444, "R3");
    tick("R3");  // outputs hold
    srch(64'h1111_2222_3333_9999, "R9");
    cfg(1, 0, 0, "R5");
    srch(64'h0000_2222_3333_4444, "R5");
    cfg(3, 0, 0, "R5");
    srch(64'h1111_0000_0000_0000, "R8");
    cfg(4, 0, 0, "R5");
    srch(64'h5555_2222_3333_4444, "R6");
    cfg(6, 0, 0, "R5");
    srch(64'h0000_0000_0000_5555, "R5");
    cfg(7, 0, 0, "R5");
    srch(64'h0000_2222_3333_4444, "R5");
    srch(64'haaaa_2222_3333_4444, "R5");
    cfg(0, 0, 64'hffff_0000_0000_ffff, "R7");
    srch(64'h0000_2222_3333_0000, "R7");
    cfg(0, 1, 64'hffff_0000_0000_ffff, "R7");
    srch(64'h0000_2222_3333_0000, "R7");
    cfg(0, 1, 64'h0000_0000_0000_0001, "R7");
    srch(64'h1111_2222_3333_4445, "R7");
    cfg(0, 1, '1, "R7");
    srch(64'h0, "R8");
    // R10: write and search together, config load and search together
    cfg_we = 1; cfg_part = 0; cfg_men = 0; cfg_mask = 0;
    cmp_en = 1; key = 64'h7;
    tick("R10");
    wr_en = 1; wr_addr = 3; wr_data = 64'h7; wr_vld = 1;
    cmp_en = 1; key = 64'h7;
    rd_en = 1; rd_addr = 3;
    tick("R10");
    srch(64'h7, "R10");
    wr(3, 64'h7, 0, "R4");
    srch(64'h7, "R4");
    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom_range(0, 9));
      logic [63:0] pat = {16'h1111, 16'(($urandom & 3)), 16'h3333, 16'(($urandom & 3))};
      if (r < 3) begin
        wr_en = 1; wr_addr = AW'($urandom); wr_data = pat; wr_vld = ($urandom & 3) != 0;
      end
      if (r == 3) begin
        cfg_we = 1; cfg_part = 3'($urandom); cfg_men = $urandom & 1;
        cfg_mask = {$urandom, $urandom} & {$urandom, $urandom};
      end
      if (r >= 4 || ($urandom & 1)) begin cmp_en = 1; key = pat; end
      if ($urandom & 1) begin rd_en = 1; rd_addr = AW'($urandom); end
      tick("R8");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule